// File: doc/BRIEF.md
# Processor Supervisor Reset Core

This block is the digital heart of a processor supervisor. It watches four conditions and drives one reset pair to the processor. The conditions are a supply-in-tolerance flag from an external comparator, an active-low pushbutton, a watchdog kick line and a two-bit watchdog period select. Reset comes up whenever the block's own reset is applied (power-up), the supply flag drops, the pushbutton is held long enough to count as a real press, or the processor stops kicking the watchdog. Once every cause has gone away, a shared stretcher keeps reset asserted for a further minimum hold time. This gives the supply and the processor time to settle.

All timing is counted in milliseconds. A millisecond tick comes from the system clock through the parameter `CLKS_PER_MS`. The pushbutton and kick inputs are asynchronous and each passes through a two-flop synchronizer. The watchdog cannot be switched off. It counts only while reset is released, and only a falling edge on the kick line restarts it. Every pin is a plain control level; there is no streaming data path, so no valid/ready handshake applies.

Top module: `supv_reset_core`

## Requirements
- R1: While `rst_n` is low, `sys_rst` is 1. After `rst_n` rises with no other cause present, `sys_rst` stays 1 for at least `HOLD_MS` ms and falls within `HOLD_MS`+2 ms.
- R2: When `supply_ok` is 0 at a clock edge, `sys_rst` is 1 after that edge, and it stays 1 for as long as `supply_ok` stays 0.
- R3: After the last reset cause clears, `sys_rst` is held for at least `HOLD_MS`*`CLKS_PER_MS` cycles and released within (`HOLD_MS`+2)*`CLKS_PER_MS` cycles.
- R4: A low level on `btn_n` lasting at least `DEB_MS`+1 ms asserts `sys_rst`. A low pulse shorter than `DEB_MS`-1 ms is bounce and leaves `sys_rst` at 0.
- R5: After a recognised press, `sys_rst` stays 1 while `btn_n` is low, and the hold time of R3 is measured from the moment `btn_n` returns high.
- R6: The `wd_sel` code picks the watchdog period P: 2'b00 gives `WD_P0_MS`, 2'b01 gives `WD_P1_MS`, 2'b10 gives `WD_P2_MS`. `sys_rst` stays 0 for (P-1)*`CLKS_PER_MS` cycles after the last falling edge of `kick`, and is 1 within P*`CLKS_PER_MS`+8 cycles of that edge when no further falling edge arrives.
- R7: Only a 1-to-0 transition of `kick` restarts the watchdog. Rising edges and a `kick` held static high or static low do not prevent the timeout.
- R8: The watchdog count is held at zero while `sys_rst` is 1. After release, no timeout occurs within (P-1)*`CLKS_PER_MS` cycles.
- R9: `sys_rst_n` is always the complement of `sys_rst`.
- R10: `wd_sel` = 2'b11 selects the same period as 2'b10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset of the block |
| supply_ok | input | 1 | Synchronous supply-in-tolerance flag, 1 = good |
| btn_n | input | 1 | Asynchronous manual reset button, active low |
| kick | input | 1 | Asynchronous watchdog kick, falling edge restarts |
| wd_sel | input | 2 | Watchdog period select |
| sys_rst | output | 1 | Reset to the processor, active high |
| sys_rst_n | output | 1 | Reset to the processor, active low |

## Verification
A supply drop reaches `sys_rst` one clock later, and the bench samples on the next falling clock edge. Inputs that pass through a synchronizer reach `sys_rst` 3 to 5 cycles later, and the millisecond tick can fall anywhere in its period. So every timed check has two sides. The "not yet" sample is taken just before the earliest legal change, counted from the stimulus in whole milliseconds. The "has happened" sample is taken after the latest legal change, plus an 8-cycle margin for the synchronizer and output registers. A design that releases early, times out on the wrong period, or restarts on a rising edge lands on the wrong side of one of these samples.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic [1:0] {
    WD_SEL_SHORT = 2'b00,
    WD_SEL_MID   = 2'b01,
    WD_SEL_LONG  = 2'b10,
    WD_SEL_ALIAS = 2'b11
  } wd_sel_e;

  function automatic int unsigned wd_period_ms(
    input logic [1:0]  sel,
    input int unsigned p0,
    input int unsigned p1,
    input int unsigned p2
  );
    case (wd_sel_e'(sel))
      WD_SEL_SHORT: return p0;
      WD_SEL_MID:   return p1;
      default:      return p2;
    endcase
  endfunction

  function automatic int unsigned max3(
    input int unsigned a,
    input int unsigned b,
    input int unsigned c
  );
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RST_VAL;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/supv_ms_tick.sv
module supv_ms_tick #(
  parameter int unsigned CLKS_PER_MS = 250000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_MS - 1);

  logic [CW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (div_q == LAST) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign tick = (div_q == LAST);
endmodule

// File: rtl/supv_debounce.sv
module supv_debounce #(
  parameter int unsigned DEB_MS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic btn_s_n,
  output logic press_req
);
  localparam int unsigned DW = $clog2(DEB_MS + 1);
  localparam logic [DW-1:0] DONE = DW'(DEB_MS);

  logic [DW-1:0] low_ms_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_ms_q  <= '0;
      press_req <= 1'b0;
    end else if (btn_s_n) begin
      low_ms_q  <= '0;
      press_req <= 1'b0;
    end else begin
      if (tick && (low_ms_q != DONE)) low_ms_q <= low_ms_q + 1'b1;
      if (low_ms_q == DONE)           press_req <= 1'b1;
    end
  end
endmodule

// File: rtl/supv_watchdog.sv
module supv_watchdog
  import supv_pkg::*;
#(
  parameter int unsigned WD_P0_MS = 150,
  parameter int unsigned WD_P1_MS = 610,
  parameter int unsigned WD_P2_MS = 1200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       hold,
  input  logic       kick_s,
  input  logic [1:0] wd_sel,
  output logic       wd_fire
);
  localparam int unsigned PMAX = max3(WD_P0_MS, WD_P1_MS, WD_P2_MS);
  localparam int unsigned WW   = $clog2(PMAX + 1);

  logic          kick_prev_q;
  logic          kick_fall;
  logic [WW-1:0] ms_q;
  logic [WW-1:0] limit_m1;

  assign limit_m1  = WW'(wd_period_ms(wd_sel, WD_P0_MS, WD_P1_MS, WD_P2_MS) - 1);
  assign kick_fall = kick_prev_q & ~kick_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kick_prev_q <= 1'b1;
    else        kick_prev_q <= kick_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_q    <= '0;
      wd_fire <= 1'b0;
    end else if (hold || kick_fall) begin
      ms_q    <= '0;
      wd_fire <= 1'b0;
    end else if (tick) begin
      if (ms_q == limit_m1) begin
        ms_q    <= '0;
        wd_fire <= 1'b1;
      end else begin
        ms_q    <= ms_q + 1'b1;
        wd_fire <= 1'b0;
      end
    end else begin
      wd_fire <= 1'b0;
    end
  end
endmodule

// File: rtl/supv_stretch.sv
module supv_stretch #(
  parameter int unsigned HOLD_MS = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cause,
  output logic rst_hi,
  output logic rst_lo_n
);
  localparam int unsigned HW = $clog2(HOLD_MS + 1);
  localparam logic [HW-1:0] FULL = HW'(HOLD_MS);

  logic [HW-1:0] quiet_ms_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_ms_q <= '0;
      rst_hi     <= 1'b1;
      rst_lo_n   <= 1'b0;
    end else if (cause) begin
      quiet_ms_q <= '0;
      rst_hi     <= 1'b1;
      rst_lo_n   <= 1'b0;
    end else if (rst_hi && tick) begin
      if (quiet_ms_q == FULL) begin
        rst_hi   <= 1'b0;
        rst_lo_n <= 1'b1;
      end else begin
        quiet_ms_q <= quiet_ms_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/supv_reset_core.sv
module supv_reset_core #(
  parameter int unsigned CLKS_PER_MS = 250000,
  parameter int unsigned DEB_MS      = 20,
  parameter int unsigned HOLD_MS     = 250,
  parameter int unsigned WD_P0_MS    = 150,
  parameter int unsigned WD_P1_MS    = 610,
  parameter int unsigned WD_P2_MS    = 1200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       btn_n,
  input  logic       kick,
  input  logic [1:0] wd_sel,
  output logic       sys_rst,
  output logic       sys_rst_n
);
  logic ms_tick;
  logic btn_s_n;
  logic kick_s;
  logic pb_req;
  logic wd_fire;
  logic any_cause;

  supv_ms_tick #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (ms_tick)
  );

  supv_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync_btn (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(btn_n),
    .q_sync (btn_s_n)
  );

  supv_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync_kick (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(kick),
    .q_sync (kick_s)
  );

  supv_debounce #(.DEB_MS(DEB_MS)) u_deb (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (ms_tick),
    .btn_s_n  (btn_s_n),
    .press_req(pb_req)
  );

  supv_watchdog #(
    .WD_P0_MS(WD_P0_MS),
    .WD_P1_MS(WD_P1_MS),
    .WD_P2_MS(WD_P2_MS)
  ) u_wd (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (ms_tick),
    .hold   (sys_rst),
    .kick_s (kick_s),
    .wd_sel (wd_sel),
    .wd_fire(wd_fire)
  );

  assign any_cause = ~supply_ok | pb_req | wd_fire;

  supv_stretch #(.HOLD_MS(HOLD_MS)) u_stretch (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (ms_tick),
    .cause   (any_cause),
    .rst_hi  (sys_rst),
    .rst_lo_n(sys_rst_n)
  );
endmodule

// File: rtl/supv_reset_core_sva.sv
module supv_reset_core_sva #(
  parameter int unsigned CLKS_PER_MS = 250000,
  parameter int unsigned HOLD_MS     = 250
) (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic pb_req,
  input logic wd_fire,
  input logic sys_rst,
  input logic sys_rst_n
);
  localparam longint unsigned MIN_CYC = longint'(HOLD_MS) * longint'(CLKS_PER_MS);
  localparam int unsigned     QW      = $clog2(MIN_CYC + 2) + 1;

  logic [QW-1:0] quiet_cyc;
  logic          cause_seen;

  assign cause_seen = ~supply_ok | pb_req | wd_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        quiet_cyc <= '0;
    else if (cause_seen)               quiet_cyc <= '0;
    else if (quiet_cyc <= QW'(MIN_CYC)) quiet_cyc <= quiet_cyc + 1'b1;
  end

  AST_OUT_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_n == ~sys_rst); // R9

  AST_SUPPLY_LOW_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> sys_rst); // R2

  AST_BTN_REQ_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    pb_req |=> sys_rst); // R5

  AST_WD_FIRE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fire |=> sys_rst); // R6

  AST_WD_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst && $past(sys_rst)) |-> !wd_fire); // R8

  AST_MIN_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> (quiet_cyc >= QW'(MIN_CYC))); // R3

  AST_POWERUP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst |-> (quiet_cyc >= QW'(MIN_CYC))); // R1
endmodule

bind supv_reset_core supv_reset_core_sva #(
  .CLKS_PER_MS(CLKS_PER_MS),
  .HOLD_MS    (HOLD_MS)
) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .supply_ok(supply_ok),
  .pb_req   (pb_req),
  .wd_fire  (wd_fire),
  .sys_rst  (sys_rst),
  .sys_rst_n(sys_rst_n)
);

// File: tb/tb_supv_reset_core.sv
module tb_supv_reset_core;
  localparam int CPM  = 8;
  localparam int DEB  = 20;
  localparam int HOLD = 250;
  localparam int P0   = 150;
  localparam int P1   = 610;
  localparam int P2   = 1200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       supply_ok = 1'b1;
  logic       btn_n = 1'b1;
  logic       kick = 1'b1;
  logic [1:0] wd_sel = 2'b00;
  logic       sys_rst;
  logic       sys_rst_n;

  int  n_chk = 0;
  int  n_bad = 0;
  int  comp_bad = 0;
  bit  kick_en = 1'b0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  supv_reset_core #(
    .CLKS_PER_MS(CPM), .DEB_MS(DEB), .HOLD_MS(HOLD),
    .WD_P0_MS(P0), .WD_P1_MS(P1), .WD_P2_MS(P2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .btn_n(btn_n),
    .kick(kick), .wd_sel(wd_sel), .sys_rst(sys_rst), .sys_rst_n(sys_rst_n)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_release();
    for (int i = 0; i < (HOLD + 50) * CPM && sys_rst; i++) @(negedge clk);
  endtask

  function automatic int period_of(input logic [1:0] s);
    return (s == 2'b00) ? P0 : (s == 2'b01) ? P1 : P2;
  endfunction

  always @(negedge clk) if (rst_n && (sys_rst === sys_rst_n)) comp_bad++;

  initial begin : kicker
    int kc = 0;
    forever begin
      @(negedge clk);
      if (kick_en) begin
        kc++;
        if (kc >= 50 * CPM) begin
          kc = 0;
          kick = 1'b0;
          @(negedge clk);
          kick = 1'b1;
        end
      end else kc = 0;
    end
  end

  initial begin : watchdog_timer
    for (int i = 0; i < 190000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    int p;
    kick_en = 1'b1;
    cyc(3);
    chk("R1 reset high in reset", sys_rst, 1'b1);
    chk("R9 low output in reset", sys_rst_n, 1'b0);
    rst_n = 1'b1;
    cyc(HOLD * CPM - 1);
    chk("R1 still held before hold time", sys_rst, 1'b1);
    cyc(2 * CPM + 1);
    chk("R1 released after hold time", sys_rst, 1'b0);

    // supply drop
    cyc(10);
    supply_ok = 1'b0;
    cyc(1);
    chk("R2 reset one cycle after supply low", sys_rst, 1'b1);
    cyc(300 * CPM);
    chk("R2 reset held while supply low", sys_rst, 1'b1);
    supply_ok = 1'b1;
    cyc(HOLD * CPM - 1);
    chk("R3 held after supply recovers", sys_rst, 1'b1);
    cyc(2 * CPM + 1);
    chk("R3 released after supply hold", sys_rst, 1'b0);

    // pushbutton bounce
    begin
      logic seen = 1'b0;
      btn_n = 1'b0;
      for (int i = 0; i < (DEB - 2) * CPM; i++) begin
        @(negedge clk);
        seen |= sys_rst;
      end
      btn_n = 1'b1;
      for (int i = 0; i < 5 * CPM; i++) begin
        @(negedge clk);
        seen |= sys_rst;
      end
      chk("R4 short low rejected", seen, 1'b0);
    end

    // real press
    btn_n = 1'b0;
    cyc((DEB + 2) * CPM);
    chk("R4 long press asserts reset", sys_rst, 1'b1);
    cyc(400 * CPM);
    chk("R5 reset held while button low", sys_rst, 1'b1);
    btn_n = 1'b1;
    cyc(HOLD * CPM - 1);
    chk("R5 held after button release", sys_rst, 1'b1);
    cyc(2 * CPM + 1);
    chk("R5 released after hold from button high", sys_rst, 1'b0);

    // watchdog sweep over all select codes
    kick_en = 1'b0;
    cyc(4);
    for (int s = 0; s < 4; s++) begin
      wd_sel = 2'(s);
      p = period_of(2'(s));
      supply_ok = 1'b0;
      cyc(2);
      supply_ok = 1'b1;
      wait_release();
      cyc((p - 1) * CPM);
      chk($sformatf("R8 no timeout right after release sel=%0d", s), sys_rst, 1'b0);
      cyc(CPM + 8);
      chk($sformatf("R8 static kick times out sel=%0d", s), sys_rst, 1'b1);
      wait_release();
      cyc(20);
      kick = 1'b0;
      cyc(2);
      kick = 1'b1;
      cyc((p - 1) * CPM - 2);
      chk($sformatf("%s period not expired sel=%0d", (s == 3) ? "R10" : "R6", s), sys_rst, 1'b0);
      cyc(CPM + 8);
      chk($sformatf("%s period expired sel=%0d", (s == 3) ? "R10" : "R6", s), sys_rst, 1'b1);
    end

    // rising edge must not restart
    wd_sel = 2'b00;
    wait_release();
    cyc(20);
    kick = 1'b0;
    cyc(40 * CPM);
    kick = 1'b1;
    cyc((P0 - 1 - 40) * CPM);
    chk("R7 before timeout after fall", sys_rst, 1'b0);
    cyc(CPM + 8);
    chk("R7 rising edge did not restart", sys_rst, 1'b1);

    // static low must not prevent timeout
    wait_release();
    cyc(20);
    kick = 1'b0;
    cyc(P0 * CPM + 8);
    chk("R7 static low times out", sys_rst, 1'b1);
    kick = 1'b1;

    chk("R9 outputs complementary throughout", comp_bad == 0, 1'b1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule